// File: doc/BRIEF.md
# Auto-Indexing Load/Store Address Unit

This unit turns one load or store command into the memory access beats that the command calls for. For each beat it produces the word address and the register index that supplies or receives the data. Single-access commands have five addressing forms. One adds an offset to a base. The other four step the base up or down by one word, either before or after the access, and return the stepped base so the caller can write it back. A pop is a post-increment load through the stack-pointer register, and a push is a pre-decrement store through it.

The multi-register form moves a contiguous range of registers, lowest index first, to or from consecutive words that start at the base. The unit sequences this burst one register per clock. It raises a busy flag while beats are still to come, and it ignores new commands while that flag is high. Memory, data movement and register-file storage are handled outside the unit. All outputs are registered, so a beat appears on the clock edge that follows the command.

Top module: `ldst_addr_unit`

## Requirements
- R1: While reset is high and after it is released, every output is 0, including the address and the write-back value.
- R2: Mode code 0 (base plus offset) produces one beat, on the edge after the command, at address base+offset. That beat has the last flag set and no base write-back.
- R3: Mode codes 1 (post-increment) and 2 (post-decrement) produce one beat at address base, with write-back enabled and the write-back value set to base+1 or base-1 respectively.
- R4: Mode codes 3 (pre-increment) and 4 (pre-decrement) produce one beat whose address and write-back value are both base+1 or both base-1, with write-back enabled.
- R5: Every single-access beat has the last flag set. In a burst, only the final beat has it.
- R6: Mode code 5 (multi) with low index not greater than high index produces one beat per clock. The register indices run from low to high, the addresses run base, base+1, and so on, and no base write-back occurs.
- R7: Mode code 5 with low index greater than high index produces no beat and never raises busy.
- R8: Busy is high exactly while burst beats remain to be emitted. A command presented while busy is high is ignored.
- R9: The register-write strobe is high only on a load beat whose register index is not 0. A load to register 0 discards its data.
- R10: Mode codes 6 and 7 produce no beat and no write-back.
- R11: Address and write-back arithmetic wraps modulo 2^16. For example, 0x0000-1 gives 0xFFFF and 0xFFFF+1 gives 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_mode | input | 3 | Addressing mode code (0 to 7) |
| cmd_load | input | 1 | 1 for load, 0 for store |
| cmd_base | input | 16 | Base register value |
| cmd_offset | input | 16 | Offset, used by mode 0 |
| cmd_reg | input | 4 | Data register, or the low index for mode 5 |
| cmd_reg_hi | input | 4 | High register index for mode 5 |
| busy | output | 1 | Burst beats still pending; commands are ignored |
| beat_valid | output | 1 | Beat present this cycle |
| beat_addr | output | 16 | Word address of the beat |
| beat_reg | output | 4 | Register index of the beat |
| beat_load | output | 1 | Beat direction, 1 for load |
| beat_rf_we | output | 1 | Register-file write strobe for this beat |
| beat_last | output | 1 | Final beat of the command |
| wb_en | output | 1 | Base write-back enable |
| wb_data | output | 16 | New base value |

## Verification
Two functions can fall in the same cycle. The first is the emission of a burst beat. The second is the arrival of a fresh command, which the unit must drop because busy is high. The bench drives single and multi commands on every cycle of a burst and in the cycle right after the final beat. A cycle-level model then checks that each burst continues with the next index and address, and that only the command arriving after busy falls produces a beat. A pop to a nonzero register also causes a register write and a base write-back on one beat, and that pairing is checked on the same edge.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic [2:0] {
    LM_OFFSET   = 3'd0,
    LM_POST_INC = 3'd1,
    LM_POST_DEC = 3'd2,
    LM_PRE_INC  = 3'd3,
    LM_PRE_DEC  = 3'd4,
    LM_MULTI    = 3'd5,
    LM_RSV6     = 3'd6,
    LM_RSV7     = 3'd7
  } ldst_mode_e;
endpackage

// File: rtl/ldst_single_calc.sv
module ldst_single_calc
  import ldst_pkg::*;
#(
  parameter int AW = 16
) (
  input  ldst_mode_e    mode,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] offset,
  output logic          single_ok,
  output logic [AW-1:0] addr,
  output logic          wb_en,
  output logic [AW-1:0] wb_data
);
  logic [AW-1:0] up, down;

  always_comb begin
    up        = base + AW'(1);
    down      = base - AW'(1);
    single_ok = 1'b1;
    addr      = base;
    wb_en     = 1'b0;
    wb_data   = base;
    case (mode)
      LM_OFFSET:   addr = base + offset;
      LM_POST_INC: begin wb_en = 1'b1; wb_data = up; end
      LM_POST_DEC: begin wb_en = 1'b1; wb_data = down; end
      LM_PRE_INC:  begin wb_en = 1'b1; wb_data = up;   addr = up;   end
      LM_PRE_DEC:  begin wb_en = 1'b1; wb_data = down; addr = down; end
      default:     single_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/ldst_burst_seq.sv
module ldst_burst_seq #(
  parameter int AW = 16,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_base,
  input  logic [RW-1:0] start_lo,
  input  logic [RW-1:0] start_hi,
  output logic          active,
  output logic [AW-1:0] cur_addr,
  output logic [RW-1:0] cur_reg,
  output logic          cur_last
);
  logic [RW-1:0] end_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      cur_addr <= '0;
      cur_reg  <= '0;
      end_q    <= '0;
    end else if (start) begin
      active   <= (start_lo != start_hi);
      cur_addr <= start_base + AW'(1);
      cur_reg  <= start_lo + RW'(1);
      end_q    <= start_hi;
    end else if (active) begin
      cur_addr <= cur_addr + AW'(1);
      cur_reg  <= cur_reg + RW'(1);
      if (cur_reg == end_q) active <= 1'b0;
    end
  end

  assign cur_last = (cur_reg == end_q);
endmodule

// File: rtl/ldst_addr_unit.sv
module ldst_addr_unit
  import ldst_pkg::*;
#(
  parameter int AW = 16,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_mode,
  input  logic          cmd_load,
  input  logic [AW-1:0] cmd_base,
  input  logic [AW-1:0] cmd_offset,
  input  logic [RW-1:0] cmd_reg,
  input  logic [RW-1:0] cmd_reg_hi,
  output logic          busy,
  output logic          beat_valid,
  output logic [AW-1:0] beat_addr,
  output logic [RW-1:0] beat_reg,
  output logic          beat_load,
  output logic          beat_rf_we,
  output logic          beat_last,
  output logic          wb_en,
  output logic [AW-1:0] wb_data
);
  ldst_mode_e    mode;
  logic          accept, multi_go, burst_load_q;
  logic          s_ok, s_wb_en;
  logic [AW-1:0] s_addr, s_wb;
  logic          seq_active, seq_last;
  logic [AW-1:0] seq_addr;
  logic [RW-1:0] seq_reg;

  assign mode     = ldst_mode_e'(cmd_mode);
  assign accept   = cmd_valid && !seq_active;
  assign multi_go = accept && (mode == LM_MULTI) && (cmd_reg <= cmd_reg_hi);
  assign busy     = seq_active;

  ldst_single_calc #(.AW(AW)) u_calc (
    .mode(mode), .base(cmd_base), .offset(cmd_offset),
    .single_ok(s_ok), .addr(s_addr), .wb_en(s_wb_en), .wb_data(s_wb)
  );

  ldst_burst_seq #(.AW(AW), .RW(RW)) u_seq (
    .clk(clk), .rst(rst), .start(multi_go),
    .start_base(cmd_base), .start_lo(cmd_reg), .start_hi(cmd_reg_hi),
    .active(seq_active), .cur_addr(seq_addr), .cur_reg(seq_reg),
    .cur_last(seq_last)
  );

  always_ff @(posedge clk) begin
    if (rst) burst_load_q <= 1'b0;
    else if (multi_go) burst_load_q <= cmd_load;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_valid <= 1'b0;
      beat_addr  <= '0;
      beat_reg   <= '0;
      beat_load  <= 1'b0;
      beat_rf_we <= 1'b0;
      beat_last  <= 1'b0;
      wb_en      <= 1'b0;
      wb_data    <= '0;
    end else begin
      beat_valid <= 1'b0;
      beat_rf_we <= 1'b0;
      beat_last  <= 1'b0;
      wb_en      <= 1'b0;
      if (seq_active) begin
        beat_valid <= 1'b1;
        beat_addr  <= seq_addr;
        beat_reg   <= seq_reg;
        beat_load  <= burst_load_q;
        beat_rf_we <= burst_load_q && (seq_reg != '0);
        beat_last  <= seq_last;
      end else if (accept && s_ok) begin
        beat_valid <= 1'b1;
        beat_addr  <= s_addr;
        beat_reg   <= cmd_reg;
        beat_load  <= cmd_load;
        beat_rf_we <= cmd_load && (cmd_reg != '0);
        beat_last  <= 1'b1;
        wb_en      <= s_wb_en;
        wb_data    <= s_wb;
      end else if (multi_go) begin
        beat_valid <= 1'b1;
        beat_addr  <= cmd_base;
        beat_reg   <= cmd_reg;
        beat_load  <= cmd_load;
        beat_rf_we <= cmd_load && (cmd_reg != '0);
        beat_last  <= (cmd_reg == cmd_reg_hi);
      end
    end
  end

  assert_last_in_beat_R5: assert property (@(posedge clk) disable iff (rst)
    beat_last |-> beat_valid);

  assert_burst_step_R6: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_last) |=> (beat_valid && !wb_en
      && (beat_reg - $past(beat_reg)) == RW'(1)
      && (beat_addr - $past(beat_addr)) == AW'(1)));

  assert_empty_burst_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && cmd_mode == 3'd5 && cmd_reg > cmd_reg_hi) |=> !beat_valid && !busy);

  assert_zero_discard_R9: assert property (@(posedge clk) disable iff (rst)
    beat_rf_we |-> (beat_valid && beat_load && beat_reg != '0));

  assert_reserved_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && cmd_mode[2:1] == 2'b11) |=> !beat_valid && !wb_en);
endmodule

// File: tb/ldst_addr_unit_bench.sv
module ldst_addr_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_mode = '0;
  logic        cmd_load = 1'b0;
  logic [15:0] cmd_base = '0, cmd_offset = '0;
  logic [3:0]  cmd_reg = '0, cmd_reg_hi = '0;
  logic        busy, beat_valid, beat_load, beat_rf_we, beat_last, wb_en;
  logic [15:0] beat_addr, wb_data;
  logic [3:0]  beat_reg;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ldst_addr_unit u_ldst_addr_unit (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .cmd_load(cmd_load), .cmd_base(cmd_base), .cmd_offset(cmd_offset),
    .cmd_reg(cmd_reg), .cmd_reg_hi(cmd_reg_hi), .busy(busy),
    .beat_valid(beat_valid), .beat_addr(beat_addr), .beat_reg(beat_reg),
    .beat_load(beat_load), .beat_rf_we(beat_rf_we), .beat_last(beat_last),
    .wb_en(wb_en), .wb_data(wb_data)
  );

  // reference model
  int          q_reg[$];
  logic [15:0] q_addr[$];
  bit          m_load;
  bit          e_valid, e_load, e_rfwe, e_last, e_wb, e_busy;
  logic [15:0] e_addr, e_wbd;
  int          e_reg;
  string       e_tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      q_reg.delete(); q_addr.delete();
      e_valid = 0; e_load = 0; e_rfwe = 0; e_last = 0; e_wb = 0;
      e_addr = 0; e_wbd = 0; e_reg = 0; e_tag = "R1"; m_load = 0;
    end else begin
      e_valid = 0; e_rfwe = 0; e_last = 0; e_wb = 0; e_tag = "R8";
      if (q_reg.size() != 0) begin
        e_valid = 1; e_addr = q_addr.pop_front(); e_reg = q_reg.pop_front();
        e_last = (q_reg.size() == 0); e_load = m_load; e_tag = "R6";
      end else if (cmd_valid) begin
        e_tag = "R2";
        if (cmd_mode <= 4) begin
          e_valid = 1; e_last = 1; e_reg = cmd_reg; e_load = cmd_load;
          case (cmd_mode)
            0: e_addr = cmd_base + cmd_offset;
            1: begin e_addr = cmd_base; e_wb = 1; e_wbd = cmd_base + 16'd1; e_tag = "R3"; end
            2: begin e_addr = cmd_base; e_wb = 1; e_wbd = cmd_base - 16'd1; e_tag = "R3"; end
            3: begin e_wbd = cmd_base + 16'd1; e_addr = e_wbd; e_wb = 1; e_tag = "R4"; end
            default: begin e_wbd = cmd_base - 16'd1; e_addr = e_wbd; e_wb = 1; e_tag = "R4"; end
          endcase
        end else if (cmd_mode == 5) begin
          e_tag = "R7";
          if (cmd_reg <= cmd_reg_hi) begin
            for (int k = cmd_reg; k <= cmd_reg_hi; k++) begin
              q_reg.push_back(k);
              q_addr.push_back(cmd_base + 16'(k - cmd_reg));
            end
            m_load = cmd_load; e_valid = 1; e_load = m_load; e_tag = "R6";
            e_addr = q_addr.pop_front(); e_reg = q_reg.pop_front();
            e_last = (q_reg.size() == 0);
          end
        end else e_tag = "R10";
      end
      e_rfwe = e_valid && e_load && (e_reg != 0);
    end
    e_busy = (q_reg.size() != 0);
  end

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(e_tag, "beat_valid", beat_valid, e_valid);
      chk(e_tag, "wb_en", wb_en, e_wb);
      chk("R5", "beat_last", beat_last, e_last);
      chk("R9", "beat_rf_we", beat_rf_we, e_rfwe);
      chk("R8", "busy", busy, e_busy);
      if (e_valid || e_tag == "R1") begin
        chk(e_tag, "beat_addr", beat_addr, e_addr);
        chk(e_tag, "beat_reg", beat_reg, e_reg);
        chk(e_tag, "beat_load", beat_load, e_load);
      end
      if (e_wb || e_tag == "R1") chk(e_tag, "wb_data", wb_data, e_wbd);
    end
  end

  task automatic issue(input bit v, input int mode, input bit ld, input logic [15:0] base,
                       input logic [15:0] off, input int lo, input int hi);
    @(negedge clk); #1;
    cmd_valid = v; cmd_mode = 3'(mode); cmd_load = ld; cmd_base = base;
    cmd_offset = off; cmd_reg = 4'(lo); cmd_reg_hi = 4'(hi);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(0, 0, 0, 16'h0, 16'h0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    idle(2);                                           // R1 after release
    issue(1, 0, 1, 16'h1000, 16'h0034, 3, 0);         // R2 offset
    issue(1, 1, 1, 16'h0200, 0, 3, 0);                // R3 pop to r3 via SP
    issue(1, 2, 0, 16'h0300, 0, 7, 0);                // R3 post-dec
    issue(1, 3, 1, 16'h0400, 0, 8, 0);                // R4 pre-inc
    issue(1, 4, 0, 16'h0500, 0, 9, 0);                // R4 push
    issue(1, 4, 1, 16'h0000, 0, 2, 0);                // R11 wrap down
    issue(1, 1, 1, 16'hFFFF, 0, 2, 0);                // R11 wrap up
    issue(1, 0, 1, 16'hFFF0, 16'h0020, 0, 0);         // R11 + R9 load to r0
    issue(1, 6, 1, 16'h1234, 0, 5, 0);                // R10
    issue(1, 7, 0, 16'h1234, 0, 5, 0);                // R10
    idle(1);
    issue(1, 5, 1, 16'h0800, 0, 2, 5);                // R6 burst
    issue(1, 1, 1, 16'h9999, 0, 1, 0);                // R8 ignored while busy
    issue(1, 5, 0, 16'h7777, 0, 0, 9);                // R8 ignored
    issue(1, 0, 1, 16'h1111, 0, 1, 0);                // R8 ignored
    issue(1, 3, 1, 16'h2000, 0, 6, 0);                // accepted after busy falls
    issue(1, 5, 1, 16'h0100, 0, 7, 3);                // R7 empty
    issue(1, 5, 1, 16'h0110, 0, 4, 4);                // R6 single-reg burst
    issue(1, 5, 1, 16'hFFFE, 0, 0, 2);                // R9 r0 + R11 wrap
    idle(3);
    issue(1, 5, 0, 16'h0040, 0, 13, 15);              // R6 store to top
    idle(4);
    issue(1, 2, 0, 16'h0050, 0, 0, 0);                // R9 store r0
    idle(3);
    rst = 1'b1; idle(2);                              // R1 mid-run reset
    #1 rst = 1'b0;
    idle(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule